// File: doc/BRIEF.md
# Supply Voltage Window Monitor

The monitor watches a stream of digitized supply-voltage samples and decides whether the supply is low enough or high enough that the motor must be stopped. Each sample is a 12-bit unsigned code with a one-cycle valid strobe. The scale is set by the parameter `MV_PER_LSB`, which defaults to 10 mV per count. Two 3-bit selects choose a lower and an upper running limit from small fixed voltage tables. The block turns those voltages into codes internally. Select value 0 on either side turns that side's check off.

A fault is raised only when two valid samples in a row fall outside the window. Each side has its own recovery policy, picked by its own mode bit:

- **Latched:** the fault stays set until a clear-fault strobe arrives while the most recent sample was inside the window.
- **Auto-clear:** the fault drops by itself after two valid samples in a row land inside the window.

The run-inhibit output goes high whenever either fault flag is set.

Top module: `supply_window_monitor`

## Requirements
- R1: After synchronous reset, both fault flags and the run-inhibit output are 0.
- R2: The lower-limit select codes 1 to 7 mean 4.5, 5, 5.5, 6, 7.5, 10 and 12.5 V, at limit code = millivolts / MV_PER_LSB. A sample counts as low when its code is strictly below the limit code; a code equal to the limit is inside.
- R3: The upper-limit select codes 1 to 7 mean 20, 22.5, 25, 27.5, 30, 32.5 and 35 V, converted to codes in the same way. A sample counts as high when its code is strictly above the limit code.
- R4: A select value of 0 disables that side, so no sample code can raise its fault.
- R5: A fault flag rises on the clock edge that takes the second of two consecutive valid out-of-window samples on its side. A single outside sample does not raise it. Cycles with the valid strobe low change nothing.
- R6: With a side's mode bit at 1 (auto-clear), its fault drops on the edge that takes the second of two consecutive valid inside samples. An outside sample in between restarts the count.
- R7: With a side's mode bit at 0 (latched), inside samples leave the fault set. A one-cycle clear strobe, given in a cycle without a valid sample, releases the fault only if the last accepted sample was inside that side's limit.
- R8: The two mode bits act independently: one side can stay latched while the other auto-clears.
- R9: The run-inhibit output equals the OR of the two fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_code_i | input | 12 | Supply voltage code |
| min_sel_i | input | 3 | Lower limit select (0 = off) |
| max_sel_i | input | 3 | Upper limit select (0 = off) |
| uv_auto_i | input | 1 | Undervoltage mode: 1 = auto-clear, 0 = latched |
| ov_auto_i | input | 1 | Overvoltage mode: 1 = auto-clear, 0 = latched |
| clr_flt_i | input | 1 | Clear-fault strobe |
| uv_flt_o | output | 1 | Undervoltage fault flag |
| ov_flt_o | output | 1 | Overvoltage fault flag |
| run_inhibit_o | output | 1 | Motor-run inhibit |

## Verification
The hardest situation to reach is one side held latched while the other recovers on its own. No single sample can be under and over at once, so this state needs a planned sequence:

1. Latch an undervoltage fault with two low samples.
2. Drive two high samples to raise the overvoltage fault on top of it.
3. Return to mid-window codes and watch only the overvoltage flag drop.

Two further sequences are needed:

- **Streak restart:** an inside–outside–inside pattern, to show that the auto-clear count starts over.
- **Clear timing:** clear strobes placed both after an outside sample and after an inside sample, so the strobe is seen to depend on the last accepted sample.

// File: rtl/svm_pkg.sv
package svm_pkg;
    localparam int unsigned CODE_W = 12;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned N_SEL  = 1 << SEL_W;

    typedef logic [CODE_W-1:0] vcode_t;
    typedef logic [SEL_W-1:0]  lsel_t;

    typedef struct packed {
        logic uv;
        logic ov;
    } flt_t;

    function automatic int unsigned low_mv(input int unsigned s);
        case (s)
            1: return 4500;
            2: return 5000;
            3: return 5500;
            4: return 6000;
            5: return 7500;
            6: return 10000;
            7: return 12500;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned high_mv(input int unsigned s);
        case (s)
            1: return 20000;
            2: return 22500;
            3: return 25000;
            4: return 27500;
            5: return 30000;
            6: return 32500;
            7: return 35000;
            default: return 0;
        endcase
    endfunction

    function automatic vcode_t mv_to_code(input int unsigned mv, input int unsigned per_lsb);
        int unsigned c;
        c = mv / per_lsb;
        if (c > (1 << CODE_W) - 1) c = (1 << CODE_W) - 1;
        return vcode_t'(c);
    endfunction
endpackage

// File: rtl/svm_limit_lut.sv
module svm_limit_lut
    import svm_pkg::*;
#(
    parameter int unsigned MV_PER_LSB = 10,
    parameter bit          UPPER      = 1'b0
) (
    input  lsel_t  sel_i,
    output vcode_t lim_o,
    output logic   en_o
);
    vcode_t tbl [N_SEL];

    assign tbl[0] = '0;
    for (genvar g = 1; g < N_SEL; g++) begin : g_entry
        if (UPPER) begin : g_hi
            assign tbl[g] = mv_to_code(high_mv(g), MV_PER_LSB);
        end else begin : g_lo
            assign tbl[g] = mv_to_code(low_mv(g), MV_PER_LSB);
        end
    end

    assign lim_o = tbl[sel_i];
    assign en_o  = (sel_i != '0);

    // R2
    always_comb begin
        if (en_o) begin
            lim_nonzero_chk: assert (lim_o != '0);
        end
    end
endmodule

// File: rtl/svm_side.sv
module svm_side
    import svm_pkg::*;
#(
    parameter bit UPPER = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   vld_i,
    input  vcode_t code_i,
    input  vcode_t lim_i,
    input  logic   en_i,
    input  logic   auto_i,
    input  logic   clr_i,
    output logic   fault_o
);
    logic outside;
    logic last_out;

    if (UPPER) begin : g_cmp_hi
        assign outside = en_i && (code_i > lim_i);
    end else begin : g_cmp_lo
        assign outside = en_i && (code_i < lim_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_o  <= 1'b0;
            last_out <= 1'b0;
        end else if (vld_i) begin
            last_out <= outside;
            if (!fault_o && outside && last_out)
                fault_o <= 1'b1;
            else if (fault_o && auto_i && !outside && !last_out)
                fault_o <= 1'b0;
        end else if (clr_i && !last_out) begin
            fault_o <= 1'b0;
        end
    end

    // R5
    rise_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> $past(vld_i && en_i));

    // R7
    fall_needs_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_o) |-> $past((vld_i && auto_i) || clr_i));

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !fault_o) |=> !fault_o);
endmodule

// File: rtl/supply_window_monitor.sv
module supply_window_monitor
    import svm_pkg::*;
#(
    parameter int unsigned MV_PER_LSB = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_vld_i,
    input  logic [11:0] smp_code_i,
    input  logic [2:0]  min_sel_i,
    input  logic [2:0]  max_sel_i,
    input  logic        uv_auto_i,
    input  logic        ov_auto_i,
    input  logic        clr_flt_i,
    output logic        uv_flt_o,
    output logic        ov_flt_o,
    output logic        run_inhibit_o
);
    localparam int unsigned N_SIDE = 2;

    lsel_t  sel  [N_SIDE];
    vcode_t lim  [N_SIDE];
    logic   en   [N_SIDE];
    logic   mode [N_SIDE];
    logic   flt  [N_SIDE];
    flt_t   flags;

    assign sel[0]  = min_sel_i;
    assign sel[1]  = max_sel_i;
    assign mode[0] = uv_auto_i;
    assign mode[1] = ov_auto_i;

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        svm_limit_lut #(.MV_PER_LSB(MV_PER_LSB), .UPPER(s == 1)) i_lut (
            .sel_i (sel[s]),
            .lim_o (lim[s]),
            .en_o  (en[s])
        );
        svm_side #(.UPPER(s == 1)) i_side (
            .clk     (clk),
            .rst     (rst),
            .vld_i   (smp_vld_i),
            .code_i  (smp_code_i),
            .lim_i   (lim[s]),
            .en_i    (en[s]),
            .auto_i  (mode[s]),
            .clr_i   (clr_flt_i),
            .fault_o (flt[s])
        );
    end

    assign flags.uv     = flt[0];
    assign flags.ov     = flt[1];
    assign uv_flt_o     = flags.uv;
    assign ov_flt_o     = flags.ov;
    assign run_inhibit_o = flags.uv | flags.ov;

    // R9
    inhibit_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_inhibit_o) |-> $past(smp_vld_i));

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        $past(rst) |-> !run_inhibit_o);
endmodule

// File: tb/test_supply_window_monitor.sv
module test_supply_window_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld_i = 1'b0;
    logic [11:0] smp_code_i = '0;
    logic [2:0]  min_sel_i = '0;
    logic [2:0]  max_sel_i = '0;
    logic        uv_auto_i = 1'b0;
    logic        ov_auto_i = 1'b0;
    logic        clr_flt_i = 1'b0;
    logic        uv_flt_o, ov_flt_o, run_inhibit_o;

    supply_window_monitor i_supply_window_monitor (
        .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .smp_code_i(smp_code_i),
        .min_sel_i(min_sel_i), .max_sel_i(max_sel_i), .uv_auto_i(uv_auto_i),
        .ov_auto_i(ov_auto_i), .clr_flt_i(clr_flt_i), .uv_flt_o(uv_flt_o),
        .ov_flt_o(ov_flt_o), .run_inhibit_o(run_inhibit_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit    uv;
        bit    ov;
        string tag;
    } exp_t;

    exp_t q[$];
    event mon_ev;
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;

    // reference model state
    bit m_uv = 0, m_ov = 0, m_lo_last = 0, m_hi_last = 0;

    function automatic int lo_lim(int s);
        int mv[8] = '{0, 4500, 5000, 5500, 6000, 7500, 10000, 12500};
        return mv[s] / 10;
    endfunction

    function automatic int hi_lim(int s);
        int mv[8] = '{0, 20000, 22500, 25000, 27500, 30000, 32500, 35000};
        return mv[s] / 10;
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.uv = m_uv; e.ov = m_ov; e.tag = tag;
        q.push_back(e);
        ->mon_ev;
        #1;
    endtask

    task automatic sample(int code, string tag);
        bit lo, hi;
        @(negedge clk);
        smp_code_i = code[11:0];
        smp_vld_i = 1'b1;
        lo = (min_sel_i != 0) && (code < lo_lim(min_sel_i));
        hi = (max_sel_i != 0) && (code > hi_lim(max_sel_i));
        if (!m_uv && lo && m_lo_last) m_uv = 1;
        else if (m_uv && uv_auto_i && !lo && !m_lo_last) m_uv = 0;
        if (!m_ov && hi && m_hi_last) m_ov = 1;
        else if (m_ov && ov_auto_i && !hi && !m_hi_last) m_ov = 0;
        m_lo_last = lo; m_hi_last = hi;
        @(posedge clk); #2;
        smp_vld_i = 1'b0;
        push(tag);
    endtask

    task automatic idle(int code, string tag);
        @(negedge clk);
        smp_code_i = code[11:0];
        @(posedge clk); #2;
        push(tag);
    endtask

    task automatic clear(string tag);
        @(negedge clk);
        clr_flt_i = 1'b1;
        if (!m_lo_last) m_uv = 0;
        if (!m_hi_last) m_ov = 0;
        @(posedge clk); #2;
        clr_flt_i = 1'b0;
        push(tag);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(mon_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (uv_flt_o !== e.uv || ov_flt_o !== e.ov ||
                    run_inhibit_o !== (e.uv | e.ov)) begin
                    errors++;
                    $display("FAIL %s: got uv=%0b ov=%0b inh=%0b expected uv=%0b ov=%0b inh=%0b",
                             e.tag, uv_flt_o, ov_flt_o, run_inhibit_o, e.uv, e.ov, e.uv | e.ov);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2; rst = 1'b0;
        push("R1 reset");

        // R2 / R5 / R7: latched undervoltage at 5.5 V
        min_sel_i = 3'd3; uv_auto_i = 0;
        sample(549, "R5 single low sample");
        idle(0, "R5 no valid strobe");
        sample(549, "R5 second low raises");
        sample(600, "R7 latched holds");
        sample(600, "R7 latched holds after two");
        clear("R7 clear after inside");
        sample(500, "R5 raise again");
        sample(500, "R5 raise again 2");
        clear("R7 clear refused after outside");
        sample(600, "R7 inside before clear");
        clear("R7 clear accepted");
        sample(550, "R2 equal is inside");
        sample(550, "R2 equal is inside 2");

        // R6 auto-clear with streak restart
        uv_auto_i = 1;
        sample(400, "R6 low");
        sample(400, "R6 low raises");
        sample(600, "R6 one inside");
        sample(400, "R6 outside breaks streak");
        sample(600, "R6 inside again");
        sample(600, "R6 two inside clears");

        // R2 full lower table
        for (int s = 1; s < 8; s++) begin
            min_sel_i = s[2:0];
            sample(lo_lim(s) - 1, "R2 table low");
            sample(lo_lim(s) - 1, "R2 table low raises");
            sample(lo_lim(s), "R2 table at limit");
            sample(lo_lim(s), "R2 table clears");
        end

        // R3 full upper table, auto mode
        min_sel_i = 0; ov_auto_i = 1;
        for (int s = 1; s < 8; s++) begin
            max_sel_i = s[2:0];
            sample(hi_lim(s) + 1, "R3 table high");
            sample(hi_lim(s) + 1, "R3 table high raises");
            sample(hi_lim(s), "R3 table at limit");
            sample(hi_lim(s), "R3 table clears");
        end

        // R4 disabled sides
        min_sel_i = 0; max_sel_i = 0;
        sample(0, "R4 low off");
        sample(0, "R4 low off 2");
        sample(4095, "R4 high off");
        sample(4095, "R4 high off 2");

        // R8 independence: UV latched, OV auto
        min_sel_i = 3'd2; max_sel_i = 3'd1; uv_auto_i = 0; ov_auto_i = 1;
        sample(100, "R8 low");
        sample(100, "R8 uv latched");
        sample(2500, "R8 high");
        sample(2500, "R9 both flags inhibit");
        sample(1000, "R8 mid");
        sample(1000, "R8 ov auto clears uv stays");
        clear("R9 clear all");

        @(negedge clk);
        ->mon_ev;
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule